// File: doc/BRIEF.md
# Multiplexed Memory-Mapped GCD Coprocessor Port

This block is a bus slave that lets a processor drive a greatest-common-divisor engine through a handful of 32-bit registers on a simple register bus (address, write strobe, write data, combinational read data). Both operands go in through one shared data register. A sequence counter steers the first write to operand n and the second to operand m. A command register starts the engine or initialises the interface. Software then polls a status word until the done flag rises.

The read path is multiplexed. An index register picks which internal value appears at the output register: the result, either stored operand, or one 32-bit slice of a 128-bit internal word. That wide word is loaded 32 bits at a time. A word-select register picks the slice, and a mask register picks which bits of the slice take the written value. One address works as a command register on writes and a status register on reads. Another works as a wide-data input on writes and the selected output on reads.

The engine is iterative. A start command becomes a short series of micro-steps: load the operands into the working registers, subtract the smaller from the larger until the two are equal or one is zero, and then raise done.

Top module: `gcd_mmio_port`

## Requirements
- R1: After reset, status (offset 0x4) reads 0, the sequence count (offset 0x0, bits 1:0) reads 0, index (0x8) reads 0, word select (0x10) reads 0, mask (0xC) reads 0xFFFFFFFF, and the output register (0x14) reads 0. Unmapped offsets read 0.
- R2: Writes to offset 0x0 are steered by the sequence count. At count 0 the value goes to n and the count becomes 1. Otherwise the value goes to m and the count becomes 2. A third or later write before a start therefore replaces m.
- R3: A command write (offset 0x4, bits 1:0 = 2, start) sets busy (status bit 0) on the next cycle. This happens only when the engine is idle and the sequence count is 2. Otherwise the start has no effect.
- R4: The result equals gcd(n, m), computed by repeated subtraction, with gcd(0, x) = x, gcd(x, 0) = x and gcd(0, 0) = 0.
- R5: Busy lasts exactly k + 3 cycles, where k is the number of subtractions. Done (status bit 1) rises in the cycle busy falls. The result is already present at index 0 one cycle before done rises.
- R6: An init command (bits 1:0 = 1 at offset 0x4) clears the sequence count, both operands, the result and done, and aborts any computation in progress on the next cycle.
- R7: The value at offset 0x14 is selected by index bits 2:0: 0 gives the result, 1 gives n, 2 gives m, 3 gives 0, and 4 to 7 give wide-word slices 0 to 3 (slice s is bits 32s+31 to 32s).
- R8: A write to offset 0x14 updates the slice chosen by word-select bits 1:0. Bits where the mask is 1 take the written value, and bits where the mask is 0 keep their old value.
- R9: A start written while busy is ignored. A valid start clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench targets gcd operands with a zero on either side or on both sides. An engine that subtracts blindly would hang on these or return 0 instead of the other operand. It counts busy cycles against a subtraction count worked out separately, which catches an extra or missing micro-step and a done flag that rises before the result settles. It sends a third operand write, an early start, a start during a run and an init in mid-run, where a faulty sequencer would corrupt n, launch on stale data or leave busy stuck. It also runs masked wide writes with partial masks on several slices, where a design that ignores the mask or picks the wrong slice would overwrite bits that should hold.

// File: rtl/gcd_mmio_port.sv
module gcd_mmio_port #(
  parameter int DW     = 32,
  parameter int WIDE_W = 128,
  parameter int AW     = 8,
  parameter int IDXW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int NW   = WIDE_W / DW;
  localparam int SELW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [AW-1:0] A_DATA = AW'(8'h00);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h04);
  localparam logic [AW-1:0] A_IDX  = AW'(8'h08);
  localparam logic [AW-1:0] A_MASK = AW'(8'h0C);
  localparam logic [AW-1:0] A_SEL  = AW'(8'h10);
  localparam logic [AW-1:0] A_OUT  = AW'(8'h14);
  localparam logic [1:0] C_INIT  = 2'd1;
  localparam logic [1:0] C_START = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} state_t;

  state_t            state_q;
  logic [1:0]        seq_q;
  logic [DW-1:0]     n_q, m_q, a_q, b_q, res_q, mask_q;
  logic              done_q;
  logic [IDXW-1:0]   idx_q;
  logic [SELW-1:0]   sel_q;
  logic [WIDE_W-1:0] wide_q;
  logic [DW-1:0]     wide_words [NW];
  logic [DW-1:0]     out_sel;

  wire wr_data  = bus_we && (bus_addr == A_DATA);
  wire wr_cmd   = bus_we && (bus_addr == A_CMD);
  wire wr_out   = bus_we && (bus_addr == A_OUT);
  wire cmd_init = wr_cmd && (bus_wdata[1:0] == C_INIT);
  wire busy     = (state_q != S_IDLE);
  wire go       = wr_cmd && (bus_wdata[1:0] == C_START) && !busy && (seq_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      n_q   <= '0;
      m_q   <= '0;
    end else if (cmd_init) begin
      seq_q <= '0;
      n_q   <= '0;
      m_q   <= '0;
    end else if (wr_data) begin
      if (seq_q == 2'd0) begin
        n_q   <= bus_wdata;
        seq_q <= 2'd1;
      end else begin
        m_q   <= bus_wdata;
        seq_q <= 2'd2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      res_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else if (cmd_init) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (go) begin
          state_q <= S_LOAD;
          done_q  <= 1'b0;
        end
        S_LOAD: begin
          a_q     <= n_q;
          b_q     <= m_q;
          state_q <= S_RUN;
        end
        S_RUN: begin
          if (a_q == '0) begin
            res_q   <= b_q;
            state_q <= S_FIN;
          end else if (b_q == '0 || a_q == b_q) begin
            res_q   <= a_q;
            state_q <= S_FIN;
          end else if (a_q > b_q) begin
            a_q <= a_q - b_q;
          end else begin
            b_q <= b_q - a_q;
          end
        end
        default: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mask_q <= '1;
      sel_q  <= '0;
      wide_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_IDX)  idx_q  <= bus_wdata[IDXW-1:0];
      if (bus_addr == A_MASK) mask_q <= bus_wdata;
      if (bus_addr == A_SEL)  sel_q  <= bus_wdata[SELW-1:0];
      if (wr_out)
        wide_q[sel_q*DW +: DW] <= (wide_q[sel_q*DW +: DW] & ~mask_q) | (bus_wdata & mask_q);
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_slice
    assign wide_words[g] = wide_q[g*DW +: DW];
  end

  always_comb begin
    out_sel = '0;
    case (int'(idx_q))
      0: out_sel = res_q;
      1: out_sel = n_q;
      2: out_sel = m_q;
      default: begin
        for (int i = 0; i < NW; i++)
          if (int'(idx_q) == i + 4) out_sel = wide_words[i];
      end
    endcase
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = DW'(seq_q);
      A_CMD:   bus_rdata = DW'({done_q, busy});
      A_IDX:   bus_rdata = DW'(idx_q);
      A_MASK:  bus_rdata = mask_q;
      A_SEL:   bus_rdata = DW'(sel_q);
      A_OUT:   bus_rdata = out_sel;
      default: bus_rdata = '0;
    endcase
  end

  AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q != 2'd3); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(seq_q) == 2'd2); // R3
  AST_DONE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy && $past(busy)); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_init |=> !busy && !done_q && seq_q == 2'd0 && res_q == '0); // R6
  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> (wide_words[$past(sel_q)] & ~$past(mask_q)) ==
               ($past(wide_words[sel_q]) & ~$past(mask_q))); // R8
  AST_NO_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done_q)); // R9
endmodule

// File: tb/gcd_mmio_port_tb.sv
`timescale 1ns/1ps
module gcd_mmio_port_tb_top;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  int compared = 0, mismatched = 0, cyc = 0;

  gcd_mmio_port dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                       .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [31:0] r_n, r_m, r_a, r_b, r_res, r_mask;
  logic [31:0] r_wide [4];
  int r_seq, r_ph, r_idx, r_sel;
  bit r_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      r_n = 0; r_m = 0; r_a = 0; r_b = 0; r_res = 0; r_mask = '1;
      r_seq = 0; r_ph = 0; r_idx = 0; r_sel = 0; r_done = 0;
      foreach (r_wide[i]) r_wide[i] = 0;
    end else if (bus_we && bus_addr == 8'h04 && bus_wdata[1:0] == 2'd1) begin
      r_ph = 0; r_done = 0; r_res = 0; r_n = 0; r_m = 0; r_seq = 0;
    end else begin
      if (r_ph == 0) begin
        if (bus_we && bus_addr == 8'h04 && bus_wdata[1:0] == 2'd2 && r_seq == 2) begin
          r_ph = 1; r_done = 0;
        end
      end else if (r_ph == 1) begin
        r_a = r_n; r_b = r_m; r_ph = 2;
      end else if (r_ph == 2) begin
        if (r_a == 0) begin r_res = r_b; r_ph = 3; end
        else if (r_b == 0 || r_a == r_b) begin r_res = r_a; r_ph = 3; end
        else if (r_a > r_b) r_a = r_a - r_b;
        else r_b = r_b - r_a;
      end else begin
        r_done = 1; r_ph = 0;
      end
      if (bus_we && bus_addr == 8'h00) begin
        if (r_seq == 0) begin r_n = bus_wdata; r_seq = 1; end
        else begin r_m = bus_wdata; r_seq = 2; end
      end
    end
    if (rst_n && bus_we) begin
      if (bus_addr == 8'h08) r_idx = int'(bus_wdata[2:0]);
      if (bus_addr == 8'h0C) r_mask = bus_wdata;
      if (bus_addr == 8'h10) r_sel = int'(bus_wdata[1:0]);
      if (bus_addr == 8'h14) r_wide[r_sel] = (r_wide[r_sel] & ~r_mask) | (bus_wdata & r_mask);
    end
  end

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h00: return 32'(r_seq);
      8'h04: return {30'd0, r_done, r_ph != 0};
      8'h08: return 32'(r_idx);
      8'h0C: return r_mask;
      8'h10: return 32'(r_sel);
      8'h14: case (r_idx)
               0: return r_res;
               1: return r_n;
               2: return r_m;
               3: return 0;
               default: return r_wide[r_idx-4];
             endcase
      default: return 0;
    endcase
  endfunction

  function automatic string areq(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R5";
      8'h14: return "R7";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [31:0] e;
      e = mread(bus_addr);
      compared++;
      if (bus_rdata !== e) begin
        mismatched++;
        $display("FAIL %s cycle %0d addr %h: got %h expected %h", areq(bus_addr), cyc, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 0;
    #2 d = bus_rdata;
  endtask

  function automatic logic [31:0] ref_gcd(logic [31:0] x, logic [31:0] y);
    logic [31:0] t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  function automatic int sub_steps(logic [31:0] x, logic [31:0] y);
    int k = 0;
    if (x == 0 || y == 0) return 0;
    while (x != y) begin
      if (x > y) x = x - y; else y = y - x;
      k++;
    end
    return k;
  endfunction

  task automatic start_count(output int bc, output logic [31:0] st);
    @(negedge clk); bus_addr = 8'h04; bus_we = 1; bus_wdata = 2;
    @(negedge clk); bus_we = 0;
    bc = 0;
    #2;
    while (bus_rdata[0] && bc < 5000) begin
      bc++;
      @(negedge clk); #2;
    end
    st = bus_rdata;
  endtask

  task automatic run_gcd(logic [31:0] x, logic [31:0] y);
    int bc;
    logic [31:0] st, v;
    wr(8'h00, x); wr(8'h00, y);
    start_count(bc, st);
    chk("R5", $sformatf("busy cycles gcd(%0d,%0d)", x, y), 32'(bc), 32'(sub_steps(x, y) + 3));
    chk("R5", "done after busy", {31'd0, st[1]}, 32'd1);
    wr(8'h08, 0);
    rd(8'h14, v);
    chk("R4", $sformatf("gcd(%0d,%0d)", x, y), v, ref_gcd(x, y));
    wr(8'h04, 1);
  endtask

  initial begin
    logic [31:0] v, st;
    int bc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h04, v); chk("R1", "status after reset", v, 0);
    rd(8'h00, v); chk("R1", "seq after reset", v, 0);
    rd(8'h0C, v); chk("R1", "mask after reset", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R1", "output after reset", v, 0);
    rd(8'h30, v); chk("R1", "unmapped offset", v, 0);

    run_gcd(12, 18); run_gcd(0, 7); run_gcd(9, 0); run_gcd(0, 0);
    run_gcd(1, 1); run_gcd(100, 75); run_gcd(17, 5); run_gcd(1071, 462);

    // R2: sequencing and replacement of m
    wr(8'h00, 40); rd(8'h00, v); chk("R2", "seq after first", v, 1);
    wr(8'h00, 11); wr(8'h00, 24);
    rd(8'h00, v); chk("R2", "seq after third", v, 2);
    wr(8'h08, 1); rd(8'h14, v); chk("R7", "index 1 gives n", v, 40);
    wr(8'h08, 2); rd(8'h14, v); chk("R2", "third write replaced m", v, 24);
    wr(8'h08, 3); rd(8'h14, v); chk("R7", "index 3 zero", v, 0);
    start_count(bc, st);
    chk("R4", "gcd after replacement busy", 32'(bc), 32'(sub_steps(40, 24) + 3));
    wr(8'h08, 0); rd(8'h14, v); chk("R4", "gcd(40,24)", v, 8);
    // R9: restart clears done
    wr(8'h04, 2); rd(8'h04, v); chk("R9", "restart clears done", v, 1);
    repeat (20) @(negedge clk);
    wr(8'h04, 1);

    // R3: start with one operand ignored
    wr(8'h00, 6); wr(8'h04, 2);
    #2 chk("R3", "start with seq 1 ignored", bus_rdata, 0);
    wr(8'h04, 1);

    // R9: start during busy ignored; R6: init aborts
    wr(8'h00, 1000); wr(8'h00, 1);
    wr(8'h04, 2);
    wr(8'h04, 2);
    #2 chk("R9", "still busy after second start", bus_rdata, 1);
    repeat (3) @(negedge clk);
    wr(8'h04, 1);
    #2 chk("R6", "init aborts busy", bus_rdata, 0);
    rd(8'h00, v); chk("R6", "init clears seq", v, 0);
    wr(8'h08, 0); rd(8'h14, v); chk("R6", "init clears result", v, 0);
    wr(8'h08, 1); rd(8'h14, v); chk("R6", "init clears n", v, 0);

    // R8: masked wide writes
    wr(8'h10, 2); wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h0C, 32'h0000_FFFF); wr(8'h14, 32'h1234_5678);
    wr(8'h08, 6); rd(8'h14, v); chk("R8", "slice 2 partial mask", v, 32'hDEAD_5678);
    wr(8'h10, 1); wr(8'h0C, 32'hF0F0_F0F0); wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h08, 5); rd(8'h14, v); chk("R8", "slice 1 masked", v, 32'hF0F0_F0F0);
    wr(8'h08, 6); rd(8'h14, v); chk("R8", "slice 2 untouched", v, 32'hDEAD_5678);
    wr(8'h0C, 0); wr(8'h14, 32'h0);
    wr(8'h08, 5); rd(8'h14, v); chk("R8", "zero mask keeps slice", v, 32'hF0F0_F0F0);
    wr(8'h10, 7); wr(8'h0C, '1); wr(8'h14, 32'hA5A5_0001);
    wr(8'h08, 7); rd(8'h14, v); chk("R7", "slice 3 via sel bits 1:0", v, 32'hA5A5_0001);
    wr(8'h08, 4); rd(8'h14, v); chk("R7", "slice 0 unwritten", v, 0);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule